// File: doc/BRIEF.md
# Configuration Port Control Sequencer

This block runs the configuration pins of a programmable-logic device from full reset until configuration is finished. After the program input is released, it clears its state for one cycle. It then waits while any outside agent holds the shared init line low. On the first rising edge of that line, seen through a synchronizer, it latches the three mode pins. A lookup turns the latched code into three choices: the clock direction (master or slave), serial or parallel loading, and the parallel width (byte or 32-bit word).

While loading, the block does four things. It drives the configuration clock in master modes. It routes the shared output pin to daisy-chain data in serial modes and to the busy flag in parallel modes. It reorders the byte-wide parallel data so that both widths reach the core with the same bit order. It disables all of this whenever the boundary-scan port claims configuration. Bitstream parsing and the CRC check are done elsewhere and report back as strobes. A CRC failure pulls the open-drain init line low until the next program pulse. A clean load-complete releases the open-drain done line and turns on its pull-up.

States: RESET (one clearing cycle) → WAIT_INIT (held-off start) → SAMPLE_MODE (mode latched) → LOAD. LOAD goes to CRC_FAIL on a CRC-failure strobe, or to DONE on a load-complete strobe with no failure. CRC_FAIL and DONE are held until program is asserted. The program input returns the block to RESET asynchronously from any state.

Top module: `cfg_port_seq`

## Requirements
- R1: While `prog_n` is low, `init_oe`=1 and `done_oe`=1 (both lines driven low), and `jtag_en`=0, `cclk_oe`=0, `dout_busy_o`=0.
- R2: Mode capture (SAMPLE_MODE) takes place at the third rising clock edge after the init pad reads high. Holding the pad low delays it indefinitely. `jtag_en` is 0 before capture and 1 from capture onward.
- R3: The captured mode is kept until the next program pulse. Changing `mode_pins` after capture has no effect on the outputs.
- R4: Mode codes: 000 master serial, 001 master 32-bit, 010 master byte, 101 slave 32-bit, 110 slave byte, 111 slave serial. Codes 011 and 100 behave as slave serial.
- R5: In LOAD, master modes give `cclk_oe`=1 with `cclk_o` changing level on every clock edge. Slave modes give `cclk_oe`=0.
- R6: In LOAD, `dout_busy_o` follows `ser_dout_i` in serial modes and `busy_i` in parallel modes. It is 0 in every other state.
- R7: In LOAD, `cfg_word` is as follows. Byte mode: `cfg_word[7-i]`=`data_pins[i]`, with the upper 24 bits zero. 32-bit mode: `cfg_word`=`data_pins`. Serial mode: `cfg_word[0]`=`serial_din`, with all other bits zero.
- R8: When `jtag_req`=1 while `jtag_en`=1, `cclk_oe`, `dout_busy_o` and `cfg_word` are all 0.
- R9: A `crc_fail_stb` in LOAD sets `init_oe`=1 from the next edge on. It stays set until program is asserted, and any later `load_done_stb` is ignored (`done_oe` stays 1).
- R10: A `load_done_stb` in LOAD without `crc_fail_stb` gives `done_oe`=0 and `done_pu`=1 from the next edge on, with `init_oe`=0.
- R11: When both strobes arrive in the same LOAD cycle, the CRC failure wins (R9 outcome).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| prog_n | input | 1 | Active-low asynchronous full reset |
| mode_pins | input | 3 | Mode select pins |
| init_pad_i | input | 1 | Pad sample of the open-drain init line |
| init_oe | output | 1 | Init line pull-down enable |
| init_o | output | 1 | Init line drive value (constant 0) |
| cclk_oe | output | 1 | Configuration clock output enable |
| cclk_o | output | 1 | Configuration clock output value |
| serial_din | input | 1 | Serial configuration data in |
| ser_dout_i | input | 1 | Daisy-chain data from the loader |
| busy_i | input | 1 | Busy flag from the loader |
| dout_busy_o | output | 1 | Shared serial-out / busy pin |
| data_pins | input | 32 | Parallel data pins |
| cfg_word | output | 32 | Reordered configuration data to the core |
| jtag_req | input | 1 | Boundary-scan configuration request |
| jtag_en | output | 1 | Boundary-scan access allowed |
| crc_fail_stb | input | 1 | CRC failure strobe |
| load_done_stb | input | 1 | Load-complete strobe |
| done_oe | output | 1 | Done line pull-down enable |
| done_o | output | 1 | Done line drive value (constant 0) |
| done_pu | output | 1 | Done line active pull-up enable |

## Verification
Program assertion acts at once, without waiting for a clock. Mode capture comes three edges after the init pad rises: two synchronizer stages, then the state register. LOAD follows one edge after capture. The strobe results appear one edge after the strobe. The data routing, clock enable and boundary-scan gating are combinational from the state and inputs. The bench counts clock edges from the pad release to the rise of `jtag_en`, and compares the count with the expected four edges (one clearing cycle plus three). For everything else, it drives inputs and samples outputs on the falling edge after the edge at which each result is due.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

    typedef enum logic [2:0] {
        ST_RESET,
        ST_WAIT_INIT,
        ST_SAMPLE_MODE,
        ST_LOAD,
        ST_CRC_FAIL,
        ST_DONE
    } cfg_state_e;

    typedef struct packed {
        logic master;
        logic parallel;
        logic wide;
    } cfg_mode_t;

    // Lookup of one mode code into its selections; unlisted codes give slave serial.
    function automatic cfg_mode_t mode_lookup(
        input logic [2:0] code,
        input logic [7:0] valid_map,
        input logic [7:0] master_map,
        input logic [7:0] par_map,
        input logic [7:0] wide_map
    );
        cfg_mode_t m;
        if (valid_map[code]) begin
            m.master   = master_map[code];
            m.parallel = par_map[code];
            m.wide     = wide_map[code];
        end else begin
            m = '{master: 1'b0, parallel: 1'b0, wide: 1'b0};
        end
        return m;
    endfunction

endpackage

// File: rtl/cfg_pad_sync.sv
module cfg_pad_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pad_i,
    output logic level_o,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pad_i};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/cfg_mode_decode.sv
module cfg_mode_decode
    import cfg_seq_pkg::*;
#(
    parameter int         MODE_W     = 3,
    parameter logic [7:0] VALID_MAP  = 8'b1110_0111,
    parameter logic [7:0] MASTER_MAP = 8'b0000_0111,
    parameter logic [7:0] PAR_MAP    = 8'b0110_0110,
    parameter logic [7:0] WIDE_MAP   = 8'b0010_0010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic [MODE_W-1:0] mode_pins_i,
    output logic [MODE_W-1:0] code_o,
    output cfg_mode_t         mode_o
);
    logic [MODE_W-1:0] code_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         code_q <= '0;
        else if (capture_i) code_q <= mode_pins_i;
    end

    assign code_o = code_q;
    assign mode_o = mode_lookup(code_q, VALID_MAP, MASTER_MAP, PAR_MAP, WIDE_MAP);
endmodule

// File: rtl/cfg_data_route.sv
module cfg_data_route
    import cfg_seq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              route_en_i,
    input  logic              scan_active_i,
    input  cfg_mode_t         mode_i,
    input  logic              serial_din_i,
    input  logic              ser_dout_i,
    input  logic              busy_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              cclk_oe_o,
    output logic              cclk_o,
    output logic              dout_busy_o,
    output logic [DATA_W-1:0] word_o
);
    localparam int PAD_W = DATA_W - BYTE_W;

    logic              osc_q;
    logic [BYTE_W-1:0] byte_rev;
    logic              live;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) osc_q <= 1'b0;
        else        osc_q <= ~osc_q;
    end

    // Narrow mode numbers pin 0 as the top bit; flip it into the wide order.
    for (genvar i = 0; i < BYTE_W; i++) begin : g_byte_rev
        assign byte_rev[i] = data_i[BYTE_W-1-i];
    end

    assign live = route_en_i & ~scan_active_i;

    always_comb begin
        cclk_oe_o   = live & mode_i.master;
        cclk_o      = osc_q;
        dout_busy_o = 1'b0;
        word_o      = '0;
        if (live) begin
            dout_busy_o = mode_i.parallel ? busy_i : ser_dout_i;
            if (!mode_i.parallel)  word_o = {{(DATA_W-1){1'b0}}, serial_din_i};
            else if (mode_i.wide)  word_o = data_i;
            else                   word_o = {{PAD_W{1'b0}}, byte_rev};
        end
    end
endmodule

// File: rtl/cfg_port_seq.sv
module cfg_port_seq
    import cfg_seq_pkg::*;
#(
    parameter int         DATA_W      = 32,
    parameter int         BYTE_W      = 8,
    parameter int         MODE_W      = 3,
    parameter int         SYNC_STAGES = 2,
    parameter bit         DONE_PULLUP = 1'b1,
    parameter logic [7:0] VALID_MAP   = 8'b1110_0111,
    parameter logic [7:0] MASTER_MAP  = 8'b0000_0111,
    parameter logic [7:0] PAR_MAP     = 8'b0110_0110,
    parameter logic [7:0] WIDE_MAP    = 8'b0010_0010
) (
    input  logic              clk,
    input  logic              prog_n,
    input  logic [MODE_W-1:0] mode_pins,
    input  logic              init_pad_i,
    output logic              init_oe,
    output logic              init_o,
    output logic              cclk_oe,
    output logic              cclk_o,
    input  logic              serial_din,
    input  logic              ser_dout_i,
    input  logic              busy_i,
    output logic              dout_busy_o,
    input  logic [DATA_W-1:0] data_pins,
    output logic [DATA_W-1:0] cfg_word,
    input  logic              jtag_req,
    output logic              jtag_en,
    input  logic              crc_fail_stb,
    input  logic              load_done_stb,
    output logic              done_oe,
    output logic              done_o,
    output logic              done_pu
);
    cfg_state_e        state_q, state_d;
    logic              init_level, init_rise;
    logic              capture;
    logic              route_en;
    logic              scan_active;
    logic [MODE_W-1:0] mode_code;
    cfg_mode_t         mode;

    cfg_pad_sync #(.STAGES(SYNC_STAGES)) u_init_sync (
        .clk     (clk),
        .rst_n   (prog_n),
        .pad_i   (init_pad_i),
        .level_o (init_level),
        .rise_o  (init_rise)
    );

    cfg_mode_decode #(
        .MODE_W     (MODE_W),
        .VALID_MAP  (VALID_MAP),
        .MASTER_MAP (MASTER_MAP),
        .PAR_MAP    (PAR_MAP),
        .WIDE_MAP   (WIDE_MAP)
    ) u_mode (
        .clk         (clk),
        .rst_n       (prog_n),
        .capture_i   (capture),
        .mode_pins_i (mode_pins),
        .code_o      (mode_code),
        .mode_o      (mode)
    );

    cfg_data_route #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_route (
        .clk           (clk),
        .rst_n         (prog_n),
        .route_en_i    (route_en),
        .scan_active_i (scan_active),
        .mode_i        (mode),
        .serial_din_i  (serial_din),
        .ser_dout_i    (ser_dout_i),
        .busy_i        (busy_i),
        .data_i        (data_pins),
        .cclk_oe_o     (cclk_oe),
        .cclk_o        (cclk_o),
        .dout_busy_o   (dout_busy_o),
        .word_o        (cfg_word)
    );

    // State register
    always_ff @(posedge clk or negedge prog_n) begin
        if (!prog_n) state_q <= ST_RESET;
        else         state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET:       state_d = ST_WAIT_INIT;
            ST_WAIT_INIT:   if (init_rise) state_d = ST_SAMPLE_MODE;
            ST_SAMPLE_MODE: state_d = ST_LOAD;
            ST_LOAD: begin
                if (crc_fail_stb)       state_d = ST_CRC_FAIL;
                else if (load_done_stb) state_d = ST_DONE;
            end
            ST_CRC_FAIL:    state_d = ST_CRC_FAIL;
            ST_DONE:        state_d = ST_DONE;
            default:        state_d = ST_RESET;
        endcase
    end

    assign capture = (state_q == ST_WAIT_INIT) && init_rise;

    // Output logic
    always_comb begin
        init_oe  = 1'b0;
        done_oe  = 1'b1;
        done_pu  = 1'b0;
        jtag_en  = 1'b0;
        route_en = 1'b0;
        unique case (state_q)
            ST_RESET:       init_oe = 1'b1;
            ST_WAIT_INIT:   ;
            ST_SAMPLE_MODE: jtag_en = 1'b1;
            ST_LOAD: begin
                jtag_en  = 1'b1;
                route_en = 1'b1;
            end
            ST_CRC_FAIL: begin
                jtag_en = 1'b1;
                init_oe = 1'b1;
            end
            ST_DONE: begin
                jtag_en = 1'b1;
                done_oe = 1'b0;
                done_pu = DONE_PULLUP;
            end
            default:        init_oe = 1'b1;
        endcase
    end

    assign scan_active = jtag_en & jtag_req;
    assign init_o      = 1'b0;
    assign done_o      = 1'b0;

    // Assertions
    assert_scan_after_rise_R2: assert property (@(posedge clk) disable iff (!prog_n)
        $rose(jtag_en) |-> $past(init_rise) && init_level);

    assert_mode_held_R3: assert property (@(posedge clk) disable iff (!prog_n)
        (jtag_en && $past(jtag_en)) |-> $stable(mode_code));

    assert_scan_excl_R8: assert property (@(posedge clk) disable iff (!prog_n)
        scan_active |-> (!cclk_oe && !dout_busy_o && cfg_word == '0));

    assert_crc_hold_R9: assert property (@(posedge clk) disable iff (!prog_n)
        (state_q == ST_LOAD && crc_fail_stb) |=> (init_oe && done_oe));

    assert_done_clean_R10: assert property (@(posedge clk) disable iff (!prog_n)
        !done_oe |-> !init_oe);

    assert_no_cclk_idle_R5: assert property (@(posedge clk) disable iff (!prog_n)
        (state_q != ST_LOAD) |-> !cclk_oe);
endmodule

// File: tb/tb_cfg_port_seq.sv
module tb_cfg_port_seq;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        prog_n = 1'b0;
    logic [2:0]  mode_pins = 3'b000;
    logic        ext_hold = 1'b0;
    logic        init_pad;
    logic        init_oe, init_o, cclk_oe, cclk_o;
    logic        serial_din = 1'b0, ser_dout_i = 1'b0, busy_i = 1'b0;
    logic        dout_busy_o;
    logic [31:0] data_pins = '0;
    logic [31:0] cfg_word;
    logic        jtag_req = 1'b0, jtag_en;
    logic        crc_fail_stb = 1'b0, load_done_stb = 1'b0;
    logic        done_oe, done_o, done_pu;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign init_pad = (init_oe || ext_hold) ? 1'b0 : 1'b1;

    cfg_port_seq dut (
        .clk(clk), .prog_n(prog_n), .mode_pins(mode_pins), .init_pad_i(init_pad),
        .init_oe(init_oe), .init_o(init_o), .cclk_oe(cclk_oe), .cclk_o(cclk_o),
        .serial_din(serial_din), .ser_dout_i(ser_dout_i), .busy_i(busy_i),
        .dout_busy_o(dout_busy_o), .data_pins(data_pins), .cfg_word(cfg_word),
        .jtag_req(jtag_req), .jtag_en(jtag_en), .crc_fail_stb(crc_fail_stb),
        .load_done_stb(load_done_stb), .done_oe(done_oe), .done_o(done_o),
        .done_pu(done_pu)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic edge_n();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Program pulse, check the reset values, then bring the block to LOAD.
    task automatic bring_up(input logic [2:0] m);
        int n = 0;
        @(negedge clk);
        prog_n = 1'b0;
        #1;
        chk("R1", "init_oe", {31'b0, init_oe}, 32'd1);
        chk("R1", "done_oe", {31'b0, done_oe}, 32'd1);
        chk("R1", "jtag_en", {31'b0, jtag_en}, 32'd0);
        chk("R1", "cclk_oe", {31'b0, cclk_oe}, 32'd0);
        chk("R1", "dout_busy", {31'b0, dout_busy_o}, 32'd0);
        @(negedge clk);
        mode_pins = m;
        prog_n = 1'b1;
        while (!jtag_en && n < 20) begin
            edge_n();
            n++;
        end
        chk("R2", "edges to capture", n, 32'd4);
        edge_n();
    endtask

    task automatic t_holdoff();
        @(negedge clk);
        prog_n = 1'b0;
        ext_hold = 1'b1;
        mode_pins = 3'b111;
        @(negedge clk);
        prog_n = 1'b1;
        repeat (10) edge_n();
        chk("R2", "jtag_en while held", {31'b0, jtag_en}, 32'd0);
        ext_hold = 1'b0;
        edge_n();
        edge_n();
        chk("R2", "jtag_en after 2 edges", {31'b0, jtag_en}, 32'd0);
        edge_n();
        chk("R2", "jtag_en after 3 edges", {31'b0, jtag_en}, 32'd1);
    endtask

    task automatic t_master_serial();
        logic c0;
        bring_up(3'b000);
        ser_dout_i = 1'b1;
        serial_din = 1'b1;
        #1;
        chk("R5", "master cclk_oe", {31'b0, cclk_oe}, 32'd1);
        chk("R6", "serial dout", {31'b0, dout_busy_o}, 32'd1);
        chk("R7", "serial word", cfg_word, 32'h1);
        c0 = cclk_o;
        edge_n();
        chk("R5", "cclk toggles", {31'b0, cclk_o}, {31'b0, ~c0});
        mode_pins = 3'b110;
        #1;
        chk("R3", "late mode change cclk_oe", {31'b0, cclk_oe}, 32'd1);
        chk("R3", "late mode change word", cfg_word, 32'h1);
        ser_dout_i = 1'b0;
        serial_din = 1'b0;
    endtask

    task automatic t_slave_byte();
        bring_up(3'b110);
        data_pins = 32'hFFFF_FF01;
        busy_i = 1'b1;
        #1;
        chk("R5", "slave cclk_oe", {31'b0, cclk_oe}, 32'd0);
        chk("R6", "parallel busy", {31'b0, dout_busy_o}, 32'd1);
        chk("R7", "byte pin0 to msb", cfg_word, 32'h80);
        data_pins = 32'h0000_00A0;
        #1;
        chk("R7", "byte reorder A0", cfg_word, 32'h05);
        busy_i = 1'b0;
    endtask

    task automatic t_master_word();
        bring_up(3'b001);
        data_pins = 32'h1234_5678;
        busy_i = 1'b1;
        ser_dout_i = 1'b0;
        #1;
        chk("R4", "001 master", {31'b0, cclk_oe}, 32'd1);
        chk("R7", "word passthrough", cfg_word, 32'h1234_5678);
        chk("R6", "word busy", {31'b0, dout_busy_o}, 32'd1);
        jtag_req = 1'b1;
        #1;
        chk("R8", "scan cclk_oe", {31'b0, cclk_oe}, 32'd0);
        chk("R8", "scan dout", {31'b0, dout_busy_o}, 32'd0);
        chk("R8", "scan word", cfg_word, 32'h0);
        jtag_req = 1'b0;
        busy_i = 1'b0;
    endtask

    task automatic t_unused_code();
        bring_up(3'b011);
        data_pins = 32'hFFFF_FFFF;
        serial_din = 1'b0;
        ser_dout_i = 1'b1;
        busy_i = 1'b0;
        #1;
        chk("R4", "unused code slave", {31'b0, cclk_oe}, 32'd0);
        chk("R4", "unused code serial dout", {31'b0, dout_busy_o}, 32'd1);
        chk("R4", "unused code serial word", cfg_word, 32'h0);
        ser_dout_i = 1'b0;
    endtask

    task automatic t_crc_fail();
        bring_up(3'b111);
        chk("R9", "init released in LOAD", {31'b0, init_oe}, 32'd0);
        crc_fail_stb = 1'b1;
        edge_n();
        crc_fail_stb = 1'b0;
        chk("R9", "init low after fail", {31'b0, init_oe}, 32'd1);
        load_done_stb = 1'b1;
        edge_n();
        load_done_stb = 1'b0;
        edge_n();
        chk("R9", "done ignored after fail", {31'b0, done_oe}, 32'd1);
        chk("R9", "init still low", {31'b0, init_oe}, 32'd1);
        chk("R6", "dout idle outside LOAD", {31'b0, dout_busy_o}, 32'd0);
    endtask

    task automatic t_done();
        bring_up(3'b010);
        load_done_stb = 1'b1;
        edge_n();
        load_done_stb = 1'b0;
        chk("R10", "done released", {31'b0, done_oe}, 32'd0);
        chk("R10", "done pullup", {31'b0, done_pu}, 32'd1);
        chk("R10", "init released", {31'b0, init_oe}, 32'd0);
        chk("R5", "no cclk after done", {31'b0, cclk_oe}, 32'd0);
        prog_n = 1'b0;
        #1;
        chk("R1", "prog async done_oe", {31'b0, done_oe}, 32'd1);
        chk("R1", "prog async jtag_en", {31'b0, jtag_en}, 32'd0);
        prog_n = 1'b1;
    endtask

    task automatic t_both_strobes();
        bring_up(3'b101);
        crc_fail_stb = 1'b1;
        load_done_stb = 1'b1;
        edge_n();
        crc_fail_stb = 1'b0;
        load_done_stb = 1'b0;
        chk("R11", "fail wins init", {31'b0, init_oe}, 32'd1);
        chk("R11", "fail wins done", {31'b0, done_oe}, 32'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        t_holdoff();
        t_master_serial();
        t_slave_byte();
        t_master_word();
        t_unused_code();
        t_crc_fail();
        t_done();
        t_both_strobes();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule